// File: doc/BRIEF.md
# Uncached Store Beat and Mask Generator

This block sits between a processor store port and a 64-bit memory-controller write port. Each store request carries a 32-bit byte address, up to 32 bits of data, a size of 1, 2 or 4 bytes, and an uncached attribute that marks the store as write-through or cache-inhibited. The block turns each request into one or two 64-bit write beats. Every beat carries a doubleword-aligned address, 64 data bits, eight byte enables and a two-bit word mask. The bus is big-endian: the byte at the lowest address uses data bits [63:56].

Most stores take the exact path. Their bytes are placed in the correct lanes of the bus and only those lanes are enabled. An uncached store that is narrower than a word, or that does not start on a word boundary, takes the widening path instead. This path reproduces the behaviour of a memory controller whose mask has only one bit per 32-bit half. The store data is rotated into a replicated word, that word is written into both halves of every beat the store touches, and both word-mask bits are set. Stores into the locked on-chip window always take the exact path.

Both ports use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A beat is consumed on an edge where `beat_valid` and `beat_ready` are both high. While a beat waits for `beat_ready`, its contents hold steady. A new request is accepted in the same cycle that the last beat of the previous request is consumed, so the block can sustain one single-beat store per cycle.

Top module: `uwb_store_beat_gen`

## Requirements
- R1: After reset, `beat_valid` is low and `req_ready` is high.
- R2: A request takes the widening path when `req_uncached` is 1 and either `req_size` is below 4 or `req_addr[1:0]` is nonzero. All other requests take the exact path.
- R3: On the exact path, the bytes of the store go to lanes `req_addr[2:0]` upward, with the most significant store byte at the lowest address. Lane k uses data bits [63-8k:56-8k] and byte-enable bit k. All other enable bits and data bits are 0.
- R4: On the widening path, the word W is `req_data` (after the masking of R9) rotated right by `((req_addr[1:0] + req_size) mod 4) * 8` bits. Every beat of the store carries {W, W}, byte enables 8'hFF and word mask 2'b11.
- R5: The first beat address is `req_addr` with bits [2:0] cleared. If `req_addr[2:0] + req_size` exceeds 8, a second beat follows at that address plus 8, and the second beat is always issued after the first. This holds on both paths.
- R6: A store whose address has bits [31:28] equal to 4'hE and lies below `L1_BASE + L1_BYTES` (base 32'hE000_0000) takes the exact path, even when it is uncached and misaligned.
- R7: On the exact path, `beat_wen[1]` is set when any of lanes 0-3 is enabled (bits [63:32]), and `beat_wen[0]` is set when any of lanes 4-7 is enabled.
- R8: While `beat_valid` is high and `beat_ready` is low, the beat is held unchanged on the next cycle. `req_ready` is high exactly when no beat is held, or when the held beat is the last beat of its request and `beat_ready` is high.
- R9: Data bits above `req_size` bytes are ignored. They are treated as zero on both paths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store request valid |
| req_ready | output | 1 | Store request accepted when high with `req_valid` |
| req_addr | input | 32 | Store byte address |
| req_data | input | 32 | Store data, right-aligned |
| req_size | input | 3 | Store size in bytes: 1, 2 or 4 |
| req_uncached | input | 1 | Write-through or cache-inhibited attribute |
| beat_valid | output | 1 | Write beat valid |
| beat_ready | input | 1 | Write beat consumed when high with `beat_valid` |
| beat_addr | output | 32 | Doubleword-aligned beat address |
| beat_data | output | 64 | Beat data, big-endian lanes |
| beat_ben | output | 8 | Byte enables, bit k for lane k |
| beat_wen | output | 2 | Word mask: bit 1 covers [63:32], bit 0 covers [31:0] |

## Verification
Two things can happen in the same cycle: the last beat of one store is consumed, and the next request is accepted. In that cycle the output registers must move straight to the new store's first beat, with no gap and no lost beat. The bench provokes this by keeping a request waiting while the beat consumer's ready is randomized. Every cycle it checks `req_ready` against the number of beats still expected and how the consumer is behaving, and it compares every consumed beat, in order, against a per-byte reference model.

// File: rtl/uwb_pkg.sv
package uwb_pkg;
  parameter int unsigned BUS_BYTES = 8;
  parameter int unsigned WORD_BYTES = 4;
  localparam int unsigned BUS_W = BUS_BYTES * 8;
  localparam int unsigned WORD_W = WORD_BYTES * 8;

  typedef struct packed {
    logic [31:0]          addr;
    logic [BUS_W-1:0]     data;
    logic [BUS_BYTES-1:0] ben;
    logic [1:0]           wen;
  } beat_t;
endpackage

// File: rtl/uwb_path_sel.sv
module uwb_path_sel #(
  parameter logic [31:0] L1_BASE  = 32'hE000_0000,
  parameter logic [31:0] L1_BYTES = 32'h0000_4000
) (
  input  logic [31:0] addr,
  input  logic [2:0]  size,
  input  logic        uncached,
  output logic        widen,
  output logic        two_beats
);
  localparam logic [31:0] L1_END = L1_BASE + L1_BYTES;

  logic in_l1;
  logic narrow_or_skew;

  always_comb begin
    in_l1          = (addr[31:28] == 4'hE) && (addr < L1_END);
    narrow_or_skew = (size != 3'd4) || (addr[1:0] != 2'b00);
    widen          = uncached && narrow_or_skew && !in_l1;
    two_beats      = ({1'b0, addr[2:0]} + {1'b0, size}) > 4'd8;
  end
endmodule

// File: rtl/uwb_lane_pack.sv
module uwb_lane_pack
  import uwb_pkg::*;
(
  input  logic [2:0]           off,
  input  logic [2:0]           size,
  input  logic [WORD_W-1:0]    data,
  output logic [BUS_W-1:0]     data0,
  output logic [BUS_W-1:0]     data1,
  output logic [BUS_BYTES-1:0] ben0,
  output logic [BUS_BYTES-1:0] ben1
);
  logic [WORD_W-1:0]      left;
  logic [2*BUS_W-1:0]     wide;
  logic [2*BUS_BYTES-1:0] en_wide;
  logic [3:0]             mask4;

  always_comb begin
    case (size)
      3'd1:    begin left = data << 24; mask4 = 4'b0001; end
      3'd2:    begin left = data << 16; mask4 = 4'b0011; end
      default: begin left = data;       mask4 = 4'b1111; end
    endcase
    wide    = {left, {(2*BUS_W-WORD_W){1'b0}}} >> {off, 3'b000};
    en_wide = {{(2*BUS_BYTES-4){1'b0}}, mask4} << off;
    data0   = wide[2*BUS_W-1:BUS_W];
    data1   = wide[BUS_W-1:0];
    ben0    = en_wide[BUS_BYTES-1:0];
    ben1    = en_wide[2*BUS_BYTES-1:BUS_BYTES];
  end
endmodule

// File: rtl/uwb_widen.sv
module uwb_widen
  import uwb_pkg::*;
(
  input  logic [1:0]        off,
  input  logic [2:0]        size,
  input  logic [WORD_W-1:0] data,
  output logic [WORD_W-1:0] word
);
  logic [1:0]          turns;
  logic [2*WORD_W-1:0] doubled;

  always_comb begin
    turns   = off + size[1:0];
    doubled = {data, data} >> {turns, 3'b000};
    word    = doubled[WORD_W-1:0];
  end
endmodule

// File: rtl/uwb_store_beat_gen.sv
module uwb_store_beat_gen
  import uwb_pkg::*;
#(
  parameter logic [31:0] L1_BASE  = 32'hE000_0000,
  parameter logic [31:0] L1_BYTES = 32'h0000_4000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [31:0]          req_addr,
  input  logic [31:0]          req_data,
  input  logic [2:0]           req_size,
  input  logic                 req_uncached,
  output logic                 beat_valid,
  input  logic                 beat_ready,
  output logic [31:0]          beat_addr,
  output logic [63:0]          beat_data,
  output logic [7:0]           beat_ben,
  output logic [1:0]           beat_wen
);
  logic              widen, two_beats, accept;
  logic [WORD_W-1:0] dmask, rep_word;
  logic [BUS_W-1:0]  ex_d0, ex_d1;
  logic [BUS_BYTES-1:0] ex_b0, ex_b1;
  beat_t first_c, second_c;
  beat_t cur_q, hold_q;
  logic  valid_q, pend_q;

  // R9: bytes above the store size are forced to zero
  always_comb begin
    case (req_size)
      3'd1:    dmask = {24'd0, req_data[7:0]};
      3'd2:    dmask = {16'd0, req_data[15:0]};
      default: dmask = req_data;
    endcase
  end

  uwb_path_sel #(.L1_BASE(L1_BASE), .L1_BYTES(L1_BYTES)) u_sel (
    .addr(req_addr), .size(req_size), .uncached(req_uncached),
    .widen(widen), .two_beats(two_beats)
  );

  uwb_lane_pack u_pack (
    .off(req_addr[2:0]), .size(req_size), .data(dmask),
    .data0(ex_d0), .data1(ex_d1), .ben0(ex_b0), .ben1(ex_b1)
  );

  uwb_widen u_widen (
    .off(req_addr[1:0]), .size(req_size), .data(dmask), .word(rep_word)
  );

  always_comb begin
    first_c.addr  = {req_addr[31:3], 3'b000};
    second_c.addr = first_c.addr + 32'd8;
    if (widen) begin
      first_c.data  = {rep_word, rep_word};
      first_c.ben   = '1;
      first_c.wen   = 2'b11;
      second_c.data = {rep_word, rep_word};
      second_c.ben  = '1;
      second_c.wen  = 2'b11;
    end else begin
      first_c.data  = ex_d0;
      first_c.ben   = ex_b0;
      first_c.wen   = {|ex_b0[3:0], |ex_b0[7:4]};
      second_c.data = ex_d1;
      second_c.ben  = ex_b1;
      second_c.wen  = {|ex_b1[3:0], |ex_b1[7:4]};
    end
  end

  assign req_ready = !valid_q || (beat_ready && !pend_q);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
      cur_q   <= '0;
      hold_q  <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      pend_q  <= two_beats;
      cur_q   <= first_c;
      hold_q  <= second_c;
    end else if (valid_q && beat_ready) begin
      if (pend_q) begin
        cur_q  <= hold_q;
        pend_q <= 1'b0;
      end else begin
        valid_q <= 1'b0;
      end
    end
  end

  assign beat_valid = valid_q;
  assign beat_addr  = cur_q.addr;
  assign beat_data  = cur_q.data;
  assign beat_ben   = cur_q.ben;
  assign beat_wen   = cur_q.wen;

  // R8: a stalled beat keeps its contents
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) &&
      $stable(beat_data) && $stable(beat_ben) && $stable(beat_wen));

  // R8: no new request while a second beat is still owed
  a_r8_block_pending: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && pend_q |-> !req_ready);

  // R5: beats are doubleword aligned
  a_r5_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> beat_addr[2:0] == 3'b000);

  // R5: second beat follows the first one doubleword higher
  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && pend_q |=> beat_valid &&
      beat_addr == $past(beat_addr) + 32'd8);

  // R4: a fully enabled beat only comes from the widening path and is replicated
  a_r4_halves_match: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ben == 8'hFF |-> beat_data[63:32] == beat_data[31:0] &&
      beat_wen == 2'b11);

  // R2: only the three legal store sizes are accepted
  a_r2_legal_size: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> req_size == 3'd1 || req_size == 3'd2 || req_size == 3'd4);
endmodule

// File: tb/tb_uwb_store_beat_gen.sv
`timescale 1ns/1ps
module tb_uwb_store_beat_gen;
  localparam logic [31:0] L1_BASE  = 32'hE000_0000;
  localparam logic [31:0] L1_BYTES = 32'h0000_4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic [2:0]  req_size = 3'd4;
  logic        req_uncached = 1'b0;
  logic        beat_valid;
  logic        beat_ready = 1'b0;
  logic [31:0] beat_addr;
  logic [63:0] beat_data;
  logic [7:0]  beat_ben;
  logic [1:0]  beat_wen;

  always #2.5 clk = ~clk;

  uwb_store_beat_gen #(.L1_BASE(L1_BASE), .L1_BYTES(L1_BYTES)) dut (.*);

  int checks = 0;
  int fails = 0;
  logic [31:0] qa[$];
  logic [63:0] qd[$];
  logic [7:0]  qb[$];
  logic [1:0]  qw[$];
  string       qt[$];

  logic        d_valid = 1'b0, d_unc = 1'b0;
  logic [31:0] d_addr = '0, d_data = '0;
  logic [2:0]  d_size = 3'd4;
  int          ready_pct = 70;
  logic        fired;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_a;
  logic [63:0] prev_d;
  logic        done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  // Reference model: per-byte placement, independent of the design structure
  task automatic expect_store(input logic [31:0] a, input logic [31:0] d,
                              input logic [2:0] s, input logic u, input string tag);
    logic [31:0] dm, w;
    logic [63:0] dd, bd[2];
    logic [7:0]  bb[2];
    bit          in_l1, wide;
    int          nb;
    logic [32:0] lim;
    dm = (s == 3'd1) ? (d & 32'hFF) : (s == 3'd2) ? (d & 32'hFFFF) : d;
    in_l1 = (a[31:28] == 4'hE) && (a < L1_BASE + L1_BYTES);
    wide = u && (s != 3'd4 || a[1:0] != 2'b00) && !in_l1;
    lim = {1'b0, a} + 33'(s);
    nb = 0;
    for (logic [32:0] b = {1'b0, a[31:3], 3'b000}; b < lim; b += 33'd8) nb++;
    bd[0] = '0; bd[1] = '0; bb[0] = '0; bb[1] = '0;
    if (wide) begin
      dd = {dm, dm} >> (((int'(a[1:0]) + int'(s)) % 4) * 8);
      w = dd[31:0];
      for (int k = 0; k < 2; k++) begin bd[k] = {w, w}; bb[k] = 8'hFF; end
    end else begin
      for (int i = 0; i < int'(s); i++) begin
        logic [31:0] ba;
        int bi, ln;
        ba = a + 32'(i);
        bi = int'(ba[31:3] - a[31:3]);
        ln = int'(ba[2:0]);
        bd[bi][63-8*ln -: 8] = 8'(dm >> (8*(int'(s)-1-i)));
        bb[bi][ln] = 1'b1;
      end
    end
    for (int k = 0; k < nb; k++) begin
      qa.push_back({a[31:3], 3'b000} + 32'(8*k));
      qd.push_back(bd[k]);
      qb.push_back(bb[k]);
      qw.push_back(wide ? 2'b11 : {|bb[k][3:0], |bb[k][7:4]});
      qt.push_back(tag.len() != 0 ? tag : (wide ? "R4" : "R3"));
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    req_valid = d_valid; req_addr = d_addr; req_data = d_data;
    req_size = d_size; req_uncached = d_unc;
    beat_ready = ($urandom % 100) < ready_pct;
    #2;
    if (prev_stall)
      chk(beat_valid && beat_addr == prev_a && beat_data == prev_d, "R8",
          $sformatf("stalled beat changed: v=%0b a=%h exp a=%h", beat_valid, beat_addr, prev_a));
    chk(req_ready == (qa.size() == 0 || (qa.size() == 1 && beat_ready)), "R8",
        $sformatf("req_ready=%0b exp %0b (owed %0d)", req_ready,
                  (qa.size() == 0 || (qa.size() == 1 && beat_ready)), qa.size()));
    chk(beat_valid == (qa.size() != 0), "R5",
        $sformatf("beat_valid=%0b exp %0b", beat_valid, qa.size() != 0));
    if (beat_valid && beat_ready) begin
      if (qa.size() == 0) chk(0, "R5", "unexpected beat, exp none");
      else begin
        logic [31:0] ea; logic [63:0] ed; logic [7:0] eb; logic [1:0] ew; string t;
        ea = qa.pop_front(); ed = qd.pop_front(); eb = qb.pop_front();
        ew = qw.pop_front(); t = qt.pop_front();
        chk(beat_addr == ea && beat_data == ed && beat_ben == eb && beat_wen == ew, t,
            $sformatf("beat a=%h d=%h be=%h we=%b exp a=%h d=%h be=%h we=%b",
                      beat_addr, beat_data, beat_ben, beat_wen, ea, ed, eb, ew));
      end
    end
    prev_stall = beat_valid && !beat_ready;
    prev_a = beat_addr; prev_d = beat_data;
    fired = req_valid && req_ready;
    if (fired) expect_store(req_addr, req_data, req_size, req_uncached, "");
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] d, input logic [2:0] s,
                      input logic u, input string tag);
    d_valid = 1'b1; d_addr = a; d_data = d; d_size = s; d_unc = u;
    do cyc(); while (!fired);
    if (tag.len() != 0) begin
      // retag the beats just queued by this directed store
      for (int k = 0; k < qt.size(); k++) qt[k] = (k >= qt.size() - 2 && qa.size() > 0) ? tag : qt[k];
    end
    d_valid = 1'b0;
  endtask

  task automatic drain();
    ready_pct = 100;
    for (int i = 0; i < 10 && qa.size() != 0; i++) cyc();
    cyc();
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(!beat_valid && req_ready, "R1",
        $sformatf("after reset valid=%0b ready=%0b exp 0/1", beat_valid, req_ready));

    // Directed corner cases, drained after each so tags apply to their own beats
    send(32'h0000_1001, 32'h0000_00AB, 3'd1, 1'b0, "R2"); drain();  // cached narrow: exact
    send(32'h0000_1004, 32'h1122_3344, 3'd4, 1'b1, "R2"); drain();  // uncached aligned word: exact
    send(32'h0000_1001, 32'h0000_00AB, 3'd1, 1'b1, "R4"); drain();  // widening, rotate 16
    send(32'h0000_2002, 32'h0000_BEEF, 3'd2, 1'b1, "R4"); drain();  // widening, rotate 0
    send(32'h0000_3006, 32'hCAFE_F00D, 3'd4, 1'b1, "R5"); drain();  // two widened beats
    send(32'h0000_4005, 32'hA1B2_C3D4, 3'd4, 1'b0, "R5"); drain();  // two exact beats
    send(32'h0000_5007, 32'h0000_5A6B, 3'd2, 1'b0, "R7"); drain();  // lane 7 then lane 0
    send(32'hE000_0101, 32'h0000_7788, 3'd2, 1'b1, "R6"); drain();  // in window: exact
    send(32'hE000_4001, 32'h0000_7788, 3'd2, 1'b1, "R6"); drain();  // past window: widened
    send(32'h0000_6003, 32'hFFFF_FF5C, 3'd1, 1'b0, "R9"); drain();  // high garbage ignored
    send(32'h0000_6003, 32'hFFFF_FF5C, 3'd1, 1'b1, "R9"); drain();

    // Random traffic with back-to-back requests and random back-pressure
    ready_pct = 60;
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a; logic [2:0] s; int pick;
      pick = $urandom % 3;
      s = (pick == 0) ? 3'd1 : (pick == 1) ? 3'd2 : 3'd4;
      a = $urandom;
      case ($urandom % 4)
        0: a[31:28] = 4'h0;
        1: a = 32'hE000_0000 + ($urandom % 32'h8000);
        default: a[31:16] = 16'h0001;
      endcase
      send(a, $urandom, s, 1'($urandom % 2), "");
      if (($urandom % 4) == 0) cyc();
    end
    drain();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule